// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is a supervision timer for a processor subsystem. It runs in one of two modes. In plain timeout mode, software only has to service it before a down-counter reaches zero. In windowed mode, the service must also land inside an open window near the end of the count, so a service that comes too early is also a fault. Only one mode is in effect at any time. A small register port sets the mode, the reload value, the window threshold and the failure action. Software services the timer by writing two keys in order.

When it detects a fault, the block raises a one-cycle request. The request goes to the reset controller as a warm reset, or to the CPU as a non-maskable interrupt, depending on configuration. The fault kind is also recorded in a sticky status register. After reset the timer is already running in plain timeout mode. To change the mode or the window, software first stops it, writes the new settings, and then starts it again.

Register map (word addresses on `regAddr`): 0 control (bit0 run, bit1 windowed mode, bit2 failure action, 1 = NMI); 1 reload value; 2 window threshold; 3 service key, which reads as zero; 4 fault status; 5 live counter, read-only. Unmapped addresses read as zero.

Top module: `wdt_dual`

## Requirements
- R1: After reset the control register reads 1 (running, plain timeout mode, reset action). The reload register holds RESET_PRELOAD, the window and status read 0, and both request outputs are low.
- R2: While running, the counter drops by exactly one per clock unless it is reloaded. While stopped, it continuously holds the reload value.
- R3: If the counter is at zero in a running cycle with no accepted service, a timeout fault occurs. This sets status bit0 and reloads the counter.
- R4: A service is a write to address 3 whose bits [15:0] equal 16'hA35C, followed by a later key write whose bits [15:0] equal 16'h5CA3. An accepted service reloads the counter. Any other key write is a bad-key fault and sets status bit2: the second key with no first key before it, the first key written twice, or any other value.
- R5: In windowed mode, a second-key write while the counter is above the window threshold is an early fault. It sets status bit1 and reloads the counter. A second-key write with the counter at or below the threshold is accepted.
- R6: Every fault produces a one-cycle pulse in the cycle after it, on `rstReq` when control bit2 is 0 or on `nmiReq` when it is 1. Both outputs are never high together.
- R7: While the timer runs, writes to the mode bit and to the window register are ignored. The run bit, the action bit and the reload register stay writable.
- R8: Writing a 1 to a status bit clears it. A fault arriving in the same cycle keeps its bit set.
- R9: While stopped, key writes have no effect and no fault of any kind is raised.
- R10: In plain timeout mode, a correctly ordered service is accepted at any counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address, for reads and writes |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for `regAddr` |
| rstReq | output | 1 | One-cycle warm reset request |
| nmiReq | output | 1 | One-cycle non-maskable interrupt request |

## Verification
On every cycle, the assertions check the following:
- The two request outputs are mutually exclusive, and any request is matched by a recorded status bit.
- The counter steps down by one whenever no reload is strobed, and a zero count without service flags a timeout.
- The mode and window stay frozen while running, and nothing is requested while stopped.
- An accepted windowed service only happens at or below the threshold.

Some behaviours can only be shown by the bench's scenarios, which it compares cycle by cycle against a behavioural model:
- the key ordering cases (lone second key, repeated first key, foreign value);
- the write-one-to-clear status behaviour;
- the reset contents;
- the full stop, reconfigure and restart sequence into windowed mode with the NMI action.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int ADDR_W = 3;
  localparam int KEY_W  = 16;
  localparam int FLT_W  = 3;

  localparam logic [KEY_W-1:0] KEY_ARM  = 16'hA35C;
  localparam logic [KEY_W-1:0] KEY_FIRE = 16'h5CA3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_RELOAD = 3'd1,
    ADDR_WINDOW = 3'd2,
    ADDR_KEY    = 3'd3,
    ADDR_STATUS = 3'd4,
    ADDR_COUNT  = 3'd5
  } wdtAddr_e;

  // bit0 timeout, bit1 early service, bit2 bad key
  typedef struct packed {
    logic badKey;
    logic early;
    logic timeout;
  } wdtFault_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic dec;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int          CNT_W         = 16,
  parameter int unsigned RESET_PRELOAD = 4095
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] windowVal,
  output logic [CNT_W-1:0] cntQ,
  output logic             cntZero,
  output logic             aboveWindow
);

  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RESET_PRELOAD);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= CNT_INIT;
    end else if (strobe.load) begin
      cntQ <= reloadVal;
    end else if (strobe.dec) begin
      cntQ <= cntQ - CNT_ONE;
    end
  end

  assign cntZero     = (cntQ == '0);
  assign aboveWindow = (cntQ > windowVal);

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int          DATA_W        = 32,
  parameter int          CNT_W         = 16,
  parameter int unsigned RESET_PRELOAD = 4095
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic              cntZero,
  input  logic              aboveWindow,
  output wdtStrobe_t        strobe,
  output logic              runQ,
  output logic              modeQ,
  output logic              actionQ,
  output logic [CNT_W-1:0]  reloadQ,
  output logic [CNT_W-1:0]  windowQ,
  output logic [FLT_W-1:0]  statusQ,
  output logic              serviceOk,
  output logic              rstReq,
  output logic              nmiReq
);

  localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(RESET_PRELOAD);
  localparam int PAD_CNT = DATA_W - CNT_W;
  localparam int PAD_CTL = DATA_W - 3;
  localparam int PAD_FLT = DATA_W - FLT_W;

  wdtAddr_e         addrSel;
  logic             wrCtrl, wrReload, wrWindow, wrKey, wrStatus;
  logic [KEY_W-1:0] keyVal;
  logic             isArm, isFire, fireArmed;
  logic             armedQ;
  wdtFault_t        fault;
  logic             anyFault;
  logic [FLT_W-1:0] clrMask;
  logic             unusedWrData;

  assign addrSel  = wdtAddr_e'(regAddr);
  assign wrCtrl   = regWrEn && (addrSel == ADDR_CTRL);
  assign wrReload = regWrEn && (addrSel == ADDR_RELOAD);
  assign wrWindow = regWrEn && (addrSel == ADDR_WINDOW) && !runQ;
  assign wrKey    = regWrEn && (addrSel == ADDR_KEY) && runQ;
  assign wrStatus = regWrEn && (addrSel == ADDR_STATUS);

  assign keyVal    = regWrData[KEY_W-1:0];
  assign isArm     = (keyVal == KEY_ARM);
  assign isFire    = (keyVal == KEY_FIRE);
  assign fireArmed = wrKey && isFire && armedQ;

  // fault decode for the current cycle
  always_comb begin
    fault         = '0;
    serviceOk     = fireArmed && !(modeQ && aboveWindow);
    fault.early   = fireArmed && modeQ && aboveWindow;
    fault.badKey  = wrKey && !(isFire && armedQ) && !(isArm && !armedQ);
    fault.timeout = runQ && cntZero && !serviceOk;
  end

  assign anyFault = |fault;

  always_comb begin
    strobe.load = !runQ || serviceOk || anyFault;
    strobe.dec  = !strobe.load;
  end

  assign clrMask      = wrStatus ? regWrData[FLT_W-1:0] : '0;
  assign unusedWrData = ^regWrData;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b1;
      modeQ   <= 1'b0;
      actionQ <= 1'b0;
      reloadQ <= RELOAD_INIT;
      windowQ <= '0;
    end else begin
      if (wrCtrl) begin
        runQ    <= regWrData[0];
        actionQ <= regWrData[2];
        if (!runQ) modeQ <= regWrData[1];
      end
      if (wrReload) reloadQ <= regWrData[CNT_W-1:0];
      if (wrWindow) windowQ <= regWrData[CNT_W-1:0];
    end
  end

  // key sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (!runQ) begin
      armedQ <= 1'b0;
    end else if (wrKey) begin
      armedQ <= isArm && !armedQ;
    end
  end

  // status and failure requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      rstReq  <= 1'b0;
      nmiReq  <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | FLT_W'(fault);
      rstReq  <= anyFault && !actionQ;
      nmiReq  <= anyFault && actionQ;
    end
  end

  always_comb begin
    regRdData = '0;
    case (addrSel)
      ADDR_CTRL:   regRdData = {{PAD_CTL{1'b0}}, actionQ, modeQ, runQ};
      ADDR_RELOAD: regRdData = {{PAD_CNT{1'b0}}, reloadQ};
      ADDR_WINDOW: regRdData = {{PAD_CNT{1'b0}}, windowQ};
      ADDR_STATUS: regRdData = {{PAD_FLT{1'b0}}, statusQ};
      ADDR_COUNT:  regRdData = {{PAD_CNT{1'b0}}, cntQ};
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/wdt_dual.sv
module wdt_dual
  import wdt_pkg::*;
#(
  parameter int          DATA_W        = 32,
  parameter int          CNT_W         = 16,
  parameter int unsigned RESET_PRELOAD = 4095
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              rstReq,
  output logic              nmiReq
);

  wdtStrobe_t       strobe;
  logic             loadStrobe;
  logic             runQ, modeQ, actionQ, serviceOk;
  logic [CNT_W-1:0] reloadQ, windowQ, cntQ;
  logic [FLT_W-1:0] statusQ;
  logic             cntZero, aboveWindow;

  assign loadStrobe = strobe.load;

  wdt_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_PRELOAD(RESET_PRELOAD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData),
    .cntQ(cntQ), .cntZero(cntZero), .aboveWindow(aboveWindow),
    .strobe(strobe),
    .runQ(runQ), .modeQ(modeQ), .actionQ(actionQ),
    .reloadQ(reloadQ), .windowQ(windowQ), .statusQ(statusQ),
    .serviceOk(serviceOk), .rstReq(rstReq), .nmiReq(nmiReq)
  );

  wdt_datapath #(
    .CNT_W(CNT_W), .RESET_PRELOAD(RESET_PRELOAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reloadVal(reloadQ), .windowVal(windowQ),
    .cntQ(cntQ), .cntZero(cntZero), .aboveWindow(aboveWindow)
  );

endmodule

// File: rtl/wdt_dual_checker.sv
module wdt_dual_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             rstReq,
  input logic             nmiReq,
  input logic             runQ,
  input logic             modeQ,
  input logic [CNT_W-1:0] windowQ,
  input logic [CNT_W-1:0] reloadQ,
  input logic [CNT_W-1:0] cntQ,
  input logic [2:0]       statusQ,
  input logic             loadStrobe,
  input logic             serviceOk
);

  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rstReq, nmiReq}));

  assert_request_logged_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq || nmiReq) |-> (statusQ != 3'b000));

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !loadStrobe) |=> (cntQ == $past(cntQ) - 1'b1));

  assert_timeout_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && cntQ == '0 && !serviceOk) |=> (statusQ[0] && cntQ == $past(reloadQ)));

  assert_window_service_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && modeQ && serviceOk) |-> (cntQ <= windowQ));

  assert_config_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> ($stable(modeQ) && $stable(windowQ)));

  assert_stopped_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> (!rstReq && !nmiReq));

endmodule

bind wdt_dual wdt_dual_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .nmiReq(nmiReq),
  .runQ(runQ), .modeQ(modeQ), .windowQ(windowQ), .reloadQ(reloadQ),
  .cntQ(cntQ), .statusQ(statusQ), .loadStrobe(loadStrobe),
  .serviceOk(serviceOk)
);

// File: tb/wdt_dual_bench.sv
`timescale 1ns/1ps
module wdt_dual_bench;

  localparam int RST_PRE = 40;
  localparam logic [31:0] K_ARM  = 32'h0000A35C;
  localparam logic [31:0] K_FIRE = 32'h00005CA3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rstReq, nmiReq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string curTag = "R2";

  always #4 clk = ~clk;

  wdt_dual #(.DATA_W(32), .CNT_W(16), .RESET_PRELOAD(RST_PRE)) u_wdt_dual (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rstReq(rstReq), .nmiReq(nmiReq)
  );

  // behavioural reference model
  bit mRun, mMode, mAct, mArm, mRst, mNmi;
  int mPre, mWin, mCnt;
  bit [2:0] mSt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 1; mMode = 0; mAct = 0; mArm = 0; mRst = 0; mNmi = 0;
      mPre = RST_PRE; mWin = 0; mCnt = RST_PRE; mSt = 0;
    end else begin
      bit svc, bad, early, tmo, nxtArm;
      int key;
      svc = 0; bad = 0; early = 0;
      nxtArm = mArm;
      key = int'(regWrData[15:0]);
      if (!mRun) nxtArm = 0;
      else if (regWrEn && regAddr == 3'd3) begin
        if (key == 'hA35C) begin
          if (mArm) bad = 1;
          nxtArm = !mArm;
        end else if (key == 'h5CA3 && mArm) begin
          if (mMode && mCnt > mWin) early = 1; else svc = 1;
          nxtArm = 0;
        end else begin
          bad = 1;
          nxtArm = 0;
        end
      end
      tmo = mRun && mCnt == 0 && !svc;
      if (!mRun || svc || bad || early || tmo) mCnt = mPre; else mCnt = mCnt - 1;
      mRst = (bad || early || tmo) && !mAct;
      mNmi = (bad || early || tmo) && mAct;
      if (regWrEn && regAddr == 3'd4) mSt = mSt & ~regWrData[2:0];
      mSt = mSt | {bad, early, tmo};
      if (regWrEn && regAddr == 3'd0) begin
        if (!mRun) mMode = regWrData[1];
        mAct = regWrData[2];
        mRun = regWrData[0];
      end
      if (regWrEn && regAddr == 3'd1) mPre = int'(regWrData[15:0]);
      if (regWrEn && regAddr == 3'd2 && !mRun) mWin = int'(regWrData[15:0]);
      mArm = nxtArm;
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, mAct, mMode, mRun};
      3'd1: return 32'(mPre);
      3'd2: return 32'(mWin);
      3'd4: return {29'd0, mSt};
      3'd5: return 32'(mCnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      check({curTag, " model rstReq"}, 32'(rstReq), 32'(mRst));
      check({curTag, " model nmiReq"}, 32'(nmiReq), 32'(mNmi));
      check({curTag, " model read"}, regRdData, modelRead(regAddr));
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      summary();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a;
    #1 d = regRdData;
  endtask

  initial begin
    logic [31:0] d, d2;
    bit seen;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;

    curTag = "R1";
    peek(3'd0, d); check("R1 ctrl reset", d, 32'd1);
    peek(3'd1, d); check("R1 reload reset", d, 32'(RST_PRE));
    peek(3'd2, d); check("R1 window reset", d, 32'd0);
    peek(3'd4, d); check("R1 status reset", d, 32'd0);
    check("R1 requests low", {30'd0, rstReq, nmiReq}, 32'd0);

    curTag = "R2";
    peek(3'd5, d); peek(3'd5, d2);
    check("R2 one step per clock", d - d2, 32'd1);

    curTag = "R3";
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk); #2;
      if (rstReq) seen = 1;
    end
    check("R3 timeout raised reset request", 32'(seen), 32'd1);
    check("R6 no nmi under reset action", 32'(nmiReq), 32'd0);
    peek(3'd4, d); check("R3 timeout status bit0", d, 32'd1);

    curTag = "R8";
    wr(3'd4, 32'h1);
    peek(3'd4, d); check("R8 write one clears", d, 32'd0);

    curTag = "R4";
    wr(3'd3, K_ARM); wr(3'd3, K_FIRE);
    peek(3'd5, d); check("R4 service reload", d, 32'(RST_PRE - 1));
    peek(3'd4, d); check("R4 service no fault", d, 32'd0);
    wr(3'd3, K_FIRE);
    check("R4 lone second key reset pulse", 32'(rstReq), 32'd1);
    peek(3'd4, d); check("R4 lone second key bad-key bit2", d, 32'd4);
    wr(3'd4, 32'h7);
    wr(3'd3, K_ARM); wr(3'd3, K_ARM);
    check("R4 repeated first key pulse", 32'(rstReq), 32'd1);
    peek(3'd4, d); check("R4 repeated first key bit2", d, 32'd4);
    wr(3'd4, 32'h7);
    wr(3'd3, 32'h00001234);
    peek(3'd4, d); check("R4 foreign key bit2", d, 32'd4);
    wr(3'd4, 32'h7);

    curTag = "R10";
    wr(3'd3, K_ARM); wr(3'd3, K_FIRE);
    peek(3'd4, d); check("R10 early service allowed in timeout mode", d, 32'd0);

    curTag = "R7";
    wr(3'd0, 32'h3);
    peek(3'd0, d); check("R7 mode locked while running", d, 32'd1);
    wr(3'd2, 32'd10);
    peek(3'd2, d); check("R7 window locked while running", d, 32'd0);

    curTag = "R9";
    wr(3'd0, 32'h0);
    wr(3'd3, K_FIRE);
    check("R9 stopped key write no request", 32'(rstReq), 32'd0);
    peek(3'd4, d); check("R9 stopped key write no status", d, 32'd0);
    peek(3'd5, d); check("R2 stopped holds reload", d, 32'(RST_PRE));

    curTag = "R7";
    wr(3'd1, 32'd30); wr(3'd2, 32'd10); wr(3'd0, 32'h6);
    peek(3'd0, d); check("R7 mode accepted when stopped", d, 32'd6);
    peek(3'd2, d); check("R7 window accepted when stopped", d, 32'd10);
    wr(3'd0, 32'h7);

    curTag = "R5";
    wr(3'd3, K_ARM); wr(3'd3, K_FIRE);
    check("R6 early fault gives nmi", 32'(nmiReq), 32'd1);
    check("R6 early fault no reset", 32'(rstReq), 32'd0);
    peek(3'd4, d); check("R5 early status bit1", d, 32'd2);
    wr(3'd4, 32'h7);
    repeat (20) @(negedge clk);
    wr(3'd3, K_ARM); wr(3'd3, K_FIRE);
    check("R5 in-window service no nmi", 32'(nmiReq), 32'd0);
    peek(3'd4, d); check("R5 in-window service no fault", d, 32'd0);

    curTag = "R6";
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk); #2;
      if (nmiReq) seen = 1;
    end
    check("R6 timeout with nmi action", 32'(seen), 32'd1);
    check("R6 nmi action no reset", 32'(rstReq), 32'd0);
    peek(3'd4, d); check("R3 windowed timeout bit0", d, 32'd1);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule